// File: doc/BRIEF.md
# Two-Channel Timer Input Capture Unit

This block timestamps edges on external pins against a free-running 8-bit auto-reload counter. Each capture channel watches one asynchronous pin. The pin passes through a synchronizer and an edge detector. When the selected edge is seen, the channel copies the counter value into its own capture register, raises its flag, and drives its interrupt request if the channel's enable bit is set. After one event the capture register is locked. It stays locked until software reads it. That read also clears the flag and re-arms the channel.

The counter advances on a count-enable strobe. When it has reached its all-ones value, the next strobe reloads a programmable start value and produces a one-cycle overflow pulse. A halt input freezes the counter and stops the capture registers from loading. Pin edges on enabled channels still set flags while halted, so the channels can act as wake-up interrupt sources. Software uses a small register port with a single address bus, a write strobe and a read strobe. Reads are combinational.

Register offsets (ADDR_W = 4): 0 edge select (bit i = channel i, 1 rising, 0 falling), 1 interrupt enable (bit i), 2 flag status (bit i, read only), 3 reload value, 4 counter value (read only), 8 + i capture register of channel i (read only; a read with the read strobe clears flag i). Unmapped offsets read as zero.

Top module: `icap_unit`

## Requirements
- R1: On each clock with cnt_tick_i high and halt_i low, the counter increments by one. If it already holds 0xFF, it instead loads the reload value, and ovf_o is high for the cycle that follows that load edge.
- R2: Edge-select bit i chooses the active edge of channel i: 1 means rising, 0 means falling. The opposite edge neither captures nor sets the flag.
- R3: A pin change becomes visible as a set flag after the third rising clock edge that follows it. The capture register receives the counter value held during the cycle in which the synchronized edge is detected.
- R4: While flag i is set, later active edges leave capture register i unchanged.
- R5: A read of capture register i returns its held value and clears flag i. An active edge that is detected in the same cycle as that read is ignored, and the flag stays clear afterwards.
- R6: irq_o[i] is high exactly when flag i and enable bit i are both set. With the enable bit at 0, an edge still sets the flag but irq_o[i] stays low.
- R7: The status register reports the flags in bits [NUM_CH-1:0]. Writes to the status register have no effect on the flags.
- R8: While halt_i is high, the counter holds its value even with cnt_tick_i high. An edge on an enabled channel sets its flag without loading its capture register. An edge on a channel whose enable bit is 0 is ignored. wake_o is high only when halt_i is high and some irq_o bit is set.
- R9: After reset, the counter, reload, edge select, enable bits, flags and capture registers are all zero, and irq_o, wake_o and ovf_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick_i | input | 1 | Counter advance strobe |
| halt_i | input | 1 | Halt mode: freeze counter and capture loading |
| cap_pin_i | input | NUM_CH | Asynchronous capture pins |
| addr_i | input | ADDR_W | Register offset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | CNT_W | Register write data |
| rd_en_i | input | 1 | Register read strobe (side effects on capture reads) |
| rd_data_o | output | CNT_W | Register read data |
| irq_o | output | NUM_CH | Per-channel interrupt request |
| wake_o | output | 1 | Wake-up request while halted |
| ovf_o | output | 1 | Counter reload pulse |

## Verification
If the lock state is wrong, it shows up at the very next capture read: the bench reads a newer counter value in place of the first timestamp. A flag that fails to clear shows on irq_o and in the status register in the cycle after the read. Counter mistakes appear in the value latched by a capture, or in the placement of the overflow pulse one cycle after the wrap edge. A halt that leaks shows up as a changed counter or capture readback as soon as halt_i is released. The bench checks each of these at the first read after the stimulus that could expose it.

// File: rtl/icap_pkg.sv
package icap_pkg;
   localparam int OFS_EDGE     = 0;
   localparam int OFS_IEN      = 1;
   localparam int OFS_STATUS   = 2;
   localparam int OFS_RELOAD   = 3;
   localparam int OFS_COUNT    = 4;
   localparam int OFS_CAP_BASE = 8;

   function automatic int cap_ofs(input int ch);
      return OFS_CAP_BASE + ch;
   endfunction
endpackage

// File: rtl/icap_counter.sv
module icap_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             halt_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             step;
   logic             at_top;

   assign step   = tick_i && !halt_i;
   assign at_top = (cnt_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= step && at_top;
         if (step) begin
            if (at_top) cnt_q <= reload_i;
            else        cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;
endmodule

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   logic synced;
   logic last_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = pin_i;
      end else if (STAGES == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= pin_i;
         end
         assign synced = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], pin_i};
         end
         assign synced = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= synced;
   end

   assign rise_o = synced && !last_q;
   assign fall_o = !synced && last_q;
endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_i,
   input  logic             rise_sel_i,
   input  logic             irq_en_i,
   input  logic             halt_i,
   input  logic             rd_clr_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             flag_o,
   output logic [CNT_W-1:0] cap_o,
   output logic             irq_o
);
   logic             rise;
   logic             fall;
   logic             hit;
   logic             take;
   logic             flag_q;
   logic [CNT_W-1:0] cap_q;

   icap_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   assign hit  = rise_sel_i ? rise : fall;
   // a software read in the same cycle wins; halted channels need their enable
   assign take = hit && !flag_q && !rd_clr_i && (!halt_i || irq_en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         cap_q  <= '0;
      end else begin
         if (rd_clr_i)  flag_q <= 1'b0;
         else if (take) flag_q <= 1'b1;
         if (take && !halt_i) cap_q <= cnt_i;
      end
   end

   assign flag_o = flag_q;
   assign cap_o  = cap_q;
   assign irq_o  = flag_q && irq_en_i;
endmodule

// File: rtl/icap_unit.sv
module icap_unit
   import icap_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int NUM_CH      = 2,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick_i,
   input  logic              halt_i,
   input  logic [NUM_CH-1:0] cap_pin_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   input  logic              rd_en_i,
   output logic [CNT_W-1:0]  rd_data_o,
   output logic [NUM_CH-1:0] irq_o,
   output logic              wake_o,
   output logic              ovf_o
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("CNT_W must be at least 2");
      end
      if (NUM_CH < 1 || NUM_CH > CNT_W) begin : g_bad_num_ch
         $error("NUM_CH must be between 1 and CNT_W");
      end
      if (OFS_CAP_BASE + NUM_CH > ADDR_SPAN) begin : g_bad_addr_w
         $error("ADDR_W too small for the capture registers");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [NUM_CH-1:0]            edge_sel_q;
   logic [NUM_CH-1:0]            irq_en_q;
   logic [CNT_W-1:0]             reload_q;
   logic [CNT_W-1:0]             cnt;
   logic [NUM_CH-1:0]            flags;
   logic [NUM_CH-1:0]            rd_clr;
   logic [NUM_CH-1:0][CNT_W-1:0] caps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_sel_q <= '0;
         irq_en_q   <= '0;
         reload_q   <= '0;
      end else if (wr_en_i) begin
         if (addr_i == ADDR_W'(OFS_EDGE))   edge_sel_q <= wr_data_i[NUM_CH-1:0];
         if (addr_i == ADDR_W'(OFS_IEN))    irq_en_q   <= wr_data_i[NUM_CH-1:0];
         if (addr_i == ADDR_W'(OFS_RELOAD)) reload_q   <= wr_data_i;
      end
   end

   icap_counter #(.CNT_W(CNT_W)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (cnt_tick_i),
      .halt_i   (halt_i),
      .reload_i (reload_q),
      .cnt_o    (cnt),
      .ovf_o    (ovf_o)
   );

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         assign rd_clr[g] = rd_en_i && (addr_i == ADDR_W'(cap_ofs(g)));

         icap_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (cap_pin_i[g]),
            .rise_sel_i (edge_sel_q[g]),
            .irq_en_i   (irq_en_q[g]),
            .halt_i     (halt_i),
            .rd_clr_i   (rd_clr[g]),
            .cnt_i      (cnt),
            .flag_o     (flags[g]),
            .cap_o      (caps[g]),
            .irq_o      (irq_o[g])
         );
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      if (addr_i == ADDR_W'(OFS_EDGE))   rd_data_o = CNT_W'(edge_sel_q);
      if (addr_i == ADDR_W'(OFS_IEN))    rd_data_o = CNT_W'(irq_en_q);
      if (addr_i == ADDR_W'(OFS_STATUS)) rd_data_o = CNT_W'(flags);
      if (addr_i == ADDR_W'(OFS_RELOAD)) rd_data_o = reload_q;
      if (addr_i == ADDR_W'(OFS_COUNT))  rd_data_o = cnt;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr_i == ADDR_W'(cap_ofs(i))) rd_data_o = caps[i];
      end
   end

   assign wake_o = halt_i && (|irq_o);
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk
   import icap_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            cnt_tick_i,
   input logic                            halt_i,
   input logic [ADDR_W-1:0]               addr_i,
   input logic                            rd_en_i,
   input logic [NUM_CH-1:0]               irq_o,
   input logic                            wake_o,
   input logic                            ovf_o,
   input logic [CNT_W-1:0]                cnt,
   input logic [CNT_W-1:0]                reload_q,
   input logic [NUM_CH-1:0]               flags,
   input logic [NUM_CH-1:0][CNT_W-1:0]    caps
);
   localparam logic [CNT_W-1:0] TOP = '1;

   // R1: plain increment below the top value
   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick_i && !halt_i && cnt != TOP) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R1: wrap loads the reload value and pulses overflow
   a_r1_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick_i && !halt_i && cnt == TOP) |=> (ovf_o && cnt == $past(reload_q)));

   // R8: counter frozen while halted
   a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      halt_i |=> (cnt == $past(cnt)));

   // R8: wake only in halt
   a_r8_wake_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> halt_i);

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         logic rd_hit;
         assign rd_hit = rd_en_i && (addr_i == ADDR_W'(cap_ofs(g)));

         // R4: locked register does not move
         a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[g] && !rd_hit) |=> (caps[g] == $past(caps[g])));

         // R5: read leaves the flag clear
         a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
            rd_hit |=> !flags[g]);

         // R6: no request without a flag
         a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            !flags[g] |-> !irq_o[g]);
      end
   endgenerate
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cnt_tick_i (cnt_tick_i),
   .halt_i     (halt_i),
   .addr_i     (addr_i),
   .rd_en_i    (rd_en_i),
   .irq_o      (irq_o),
   .wake_o     (wake_o),
   .ovf_o      (ovf_o),
   .cnt        (cnt),
   .reload_q   (reload_q),
   .flags      (flags),
   .caps       (caps)
);

// File: tb/icap_unit_tb.sv
module icap_unit_tb;
   localparam int CNT_W  = 8;
   localparam int NUM_CH = 2;
   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_EDGE = 4'd0;
   localparam logic [ADDR_W-1:0] A_IEN  = 4'd1;
   localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
   localparam logic [ADDR_W-1:0] A_REL  = 4'd3;
   localparam logic [ADDR_W-1:0] A_CNT  = 4'd4;
   localparam logic [ADDR_W-1:0] A_CAP0 = 4'd8;
   localparam logic [ADDR_W-1:0] A_CAP1 = 4'd9;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic              halt = 1'b0;
   logic [NUM_CH-1:0] pins = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr_en = 1'b0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic              rd_en = 1'b0;
   logic [CNT_W-1:0]  rd_data;
   logic [NUM_CH-1:0] irq;
   logic              wake;
   logic              ovf;

   int n_chk  = 0;
   int n_fail = 0;

   logic [CNT_W-1:0] exp_q[$];
   string            tag_q[$];

   icap_unit #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_tick_i (tick),
      .halt_i     (halt),
      .cap_pin_i  (pins),
      .addr_i     (addr),
      .wr_en_i    (wr_en),
      .wr_data_i  (wr_data),
      .rd_en_i    (rd_en),
      .rd_data_o  (rd_data),
      .irq_o      (irq),
      .wake_o     (wake),
      .ovf_o      (ovf)
   );

   // monitor: compares each read against the next queued expectation
   always @(negedge clk) begin : mon
      logic [CNT_W-1:0] e;
      string t;
      #1;
      if (rd_en) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard: read with no expectation, actual %h expected none", rd_data);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", t, rd_data, e);
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] e, input string tag);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic set_pin(input int ch, input logic v);
      @(negedge clk);
      pins[ch] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic port_now(input string tag, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
      #1;
      chk(tag, act, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state
      port_now("R9 irq", CNT_W'(irq), 8'h00);
      port_now("R9 wake/ovf", {6'd0, wake, ovf}, 8'h00);
      rd(A_STAT, 8'h00, "R9 status");
      rd(A_CNT,  8'h00, "R9 count");
      rd(A_REL,  8'h00, "R9 reload");
      rd(A_CAP0, 8'h00, "R9 cap0");

      // R1: count to top, then wrap to the reload value
      wr(A_REL, 8'hF0);
      rd(A_REL, 8'hF0, "R1 reload readback");
      ticks(255);
      rd(A_CNT, 8'hFF, "R1 count at top");
      ticks(1);
      port_now("R1 ovf pulse", CNT_W'(ovf), 8'h01);
      rd(A_CNT, 8'hF0, "R1 count after reload");
      chk("R1 ovf single cycle", CNT_W'(ovf), 8'h00);

      // R2/R3: ch0 rising, ch1 falling, both enabled
      wr(A_EDGE, 8'h01);
      wr(A_IEN,  8'h03);
      set_pin(1, 1'b1);
      rd(A_STAT, 8'h00, "R2 ch1 ignores rising");
      @(negedge clk); pins[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      port_now("R3 no flag before third edge", CNT_W'(irq), 8'h00);
      @(negedge clk);
      port_now("R3 flag after third edge", CNT_W'(irq), 8'h01);
      rd(A_STAT, 8'h01, "R7 status shows ch0");

      // R4: lockout while flagged
      ticks(5);
      set_pin(0, 1'b0);
      set_pin(0, 1'b1);
      rd(A_CAP0, 8'hF0, "R4 first timestamp kept");
      rd(A_STAT, 8'h00, "R5 flag cleared by read");
      port_now("R6 irq drops after clear", CNT_W'(irq), 8'h00);
      set_pin(0, 1'b0);
      set_pin(0, 1'b1);
      rd(A_CAP0, 8'hF5, "R3 recapture after re-arm");
      set_pin(1, 1'b0);
      port_now("R2 ch1 falling irq", CNT_W'(irq), 8'h02);
      rd(A_CAP1, 8'hF5, "R2 ch1 falling capture");

      // R6: enable off, flag still set
      wr(A_IEN, 8'h00);
      set_pin(0, 1'b0);
      set_pin(0, 1'b1);
      rd(A_STAT, 8'h01, "R6 flag without enable");
      port_now("R6 irq masked", CNT_W'(irq), 8'h00);
      rd(A_CAP0, 8'hF5, "R6 capture readback");

      // R5: edge in the same cycle as the read
      wr(A_IEN, 8'h01);
      set_pin(0, 1'b0);
      set_pin(0, 1'b1);
      ticks(3);
      set_pin(0, 1'b0);
      @(negedge clk); pins[0] = 1'b1;
      @(negedge clk);
      rd(A_CAP0, 8'hF5, "R5 read returns old value");
      repeat (4) @(negedge clk);
      rd(A_STAT, 8'h00, "R5 colliding edge ignored");
      port_now("R5 irq stays low", CNT_W'(irq), 8'h00);

      // R8: halt mode
      @(negedge clk); halt = 1'b1;
      ticks(10);
      rd(A_CNT, 8'hF8, "R8 counter frozen");
      set_pin(0, 1'b0);
      set_pin(0, 1'b1);
      port_now("R8 wake request", {6'd0, wake, irq[0]}, 8'h03);
      rd(A_CAP0, 8'hF5, "R8 capture not loaded in halt");
      set_pin(1, 1'b1);
      set_pin(1, 1'b0);
      rd(A_STAT, 8'h00, "R8 disabled channel ignored in halt");
      @(negedge clk); halt = 1'b0;

      // R7: status write has no effect
      set_pin(0, 1'b0);
      set_pin(0, 1'b1);
      port_now("R8 no wake when running", {7'd0, wake}, 8'h00);
      wr(A_STAT, 8'h00);
      rd(A_STAT, 8'h01, "R7 status write ignored");
      rd(A_CAP0, 8'hF8, "R3 capture after halt");

      repeat (3) @(negedge clk);
      chk("scoreboard drained", CNT_W'(exp_q.size()), 8'h00);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule